// File: doc/BRIEF.md
# Shared-Bus Configuration Register Latch Bank

This block is the receiving end of a narrow host port. Over one shared 8-bit data bus, the host loads three 8-bit configuration registers: a system control register, a monitor routing register and a clock control register. Each register has its own active-low load strobe. A common active-low output enable qualifies every transfer.

A write follows a fixed sequence. The host puts data on the bus, pulls the enable low, pulls one strobe low and then releases that strobe. The register loads on the low-to-high transition of its strobe. All control inputs and the data bus pass through two-flop synchronizers. While the strobe is low and the enable is active, the bus value is copied into a staging register. The addressed register takes that staged value when the strobe edge is detected. Because of this, the idle-high bus the host leaves after a write can never be captured.

The block also decodes its registers into registered status outputs:
- from the clock register: a sample-rate index, an external-sync flag and an external clock mode;
- from the system register: a hardware mute and a codec power-down level.

A sticky error flag reports clock or system encodings that are not allowed. Only reset clears it.

Top module: `cfg_latch_bank`

## Requirements
- R1: Synchronous active-high reset sets all three registers to 0x00, rate_idx to 0, ext_mode to 0, ext_sync to 0, mute to 0, codec_pd to 1 and cfg_err to 0.
- R2: A register loads the bus value present while its strobe (ld_sys_n, ld_mon_n, ld_clk_n) was low with oe_n low, and only after that strobe returns high; the other two registers are unchanged.
- R3: A strobe pulse while oe_n is high changes no register.
- R4: The all-ones bus driven after a write is never loaded; the register keeps the written value.
- R5: When clock register bit 3 is 0 (internal sync), ext_sync is 0, ext_mode is 0 and rate_idx equals clock register bits 2:0; codes 0 to 5 raise no error, and bits 7:5 do not affect the decode.
- R6: With internal sync, rate codes 6 and 7 set cfg_err.
- R7: When clock register bit 3 is 1, ext_sync is 1 and rate_idx is 0. The pair {bit 4, bits 2:0} decodes as follows: 0,000 gives ext_mode 0 (S/PDIF); 0,010 gives ext_mode 1 (word clock 1x); 1,010 gives ext_mode 2 (word clock 256x). None of these raises an error, and bits 7:5 do not affect the decode.
- R8: With external sync, any other {bit 4, bits 2:0} pattern sets cfg_err and drives ext_mode to 3.
- R9: System register bits 5:4 equal to 2'b10 set cfg_err; the values 00, 01 and 11 do not.
- R10: cfg_err is sticky: once set it stays 1 until reset, even after legal values are written.
- R11: mute follows system register bit 2. codec_pd is the inverse of system register bit 7, so it is 1 when bit 7 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_d | input | 8 | Shared configuration data bus |
| oe_n | input | 1 | Active-low bus output enable |
| ld_sys_n | input | 1 | Active-low load strobe, system control register |
| ld_mon_n | input | 1 | Active-low load strobe, monitor routing register |
| ld_clk_n | input | 1 | Active-low load strobe, clock control register |
| sys_reg | output | 8 | System control register contents |
| mon_reg | output | 8 | Monitor routing register contents |
| clk_reg | output | 8 | Clock control register contents |
| rate_idx | output | 3 | Internal sample-rate index |
| ext_mode | output | 2 | External clock mode (0 S/PDIF, 1 word 1x, 2 word 256x, 3 invalid) |
| ext_sync | output | 1 | 1 when external sync is selected |
| mute | output | 1 | Hardware mute level |
| codec_pd | output | 1 | Codec power-down, active high |
| cfg_err | output | 1 | Sticky illegal-encoding flag |

## Verification
The bench looks at a register while its strobe is still held low. A design that loads on the falling edge, or one that is transparent while the strobe is low, would already show the new value at that point. It also pulses a strobe with the enable inactive, and holds the bus at all ones after each write. A design that ignores the enable, or that samples the bus at the synchronized edge instead of staging it, would then pick up 0x55 or 0xFF. For decoding, the bench walks every legal internal and external clock pattern with the don't-care upper bits set. It then applies each illegal class one at a time, with a reset between them, and writes a legal value after an error. A non-sticky flag, a decoder that compares whole bytes, or one that accepts the forbidden 10 input mode would each show a wrong flag or mode.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int DATA_W   = 8;
  localparam int NUM_REGS = 3;
  localparam int SYNC_STG = 2;

  // register slot order (strobe index)
  localparam int SLOT_SYS = 0;
  localparam int SLOT_MON = 1;
  localparam int SLOT_CLK = 2;

  // clock register fields
  localparam int CK_RATE_LO = 0;
  localparam int CK_RATE_HI = 2;
  localparam int CK_SYNC    = 3;
  localparam int CK_SCALE   = 4;
  localparam int RATE_MAX   = 5;

  // system register fields
  localparam int SY_MUTE    = 2;
  localparam int SY_MODE_LO = 4;
  localparam int SY_MODE_HI = 5;
  localparam int SY_PWR     = 7;

  typedef enum logic [1:0] {
    EXT_SPDIF = 2'd0,
    EXT_WC1   = 2'd1,
    EXT_WC256 = 2'd2,
    EXT_BAD   = 2'd3
  } ext_mode_t;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/cfg_reg_file.sv
module cfg_reg_file #(
  parameter int N  = 3,
  parameter int DW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         strb_n,
  input  logic                 oe_n,
  input  logic [DW-1:0]        bus,
  output logic [N-1:0][DW-1:0] regs
);
  logic [N-1:0]  strb_prev;
  logic [DW-1:0] stage;
  logic          stg_vld;
  logic          any_low;

  assign any_low = ~&strb_n;

  // staging: capture only while a strobe is low and the bus is enabled
  always_ff @(posedge clk) begin
    if (rst) begin
      strb_prev <= '1;
      stage     <= '0;
      stg_vld   <= 1'b0;
    end else begin
      strb_prev <= strb_n;
      if (oe_n) begin
        stg_vld <= 1'b0;
      end else if (any_low) begin
        stage   <= bus;
        stg_vld <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_reg
    logic rise;
    assign rise = strb_n[g] & ~strb_prev[g];
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= '0;
      else if (rise && stg_vld && !oe_n)
        regs[g] <= stage;
    end
  end
endmodule

// File: rtl/cfg_decode.sv
module cfg_decode
  import cfg_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] clk_reg,
  input  logic [DW-1:0] sys_reg,
  output logic [2:0]    rate_idx,
  output ext_mode_t     ext_mode,
  output logic          ext_sync,
  output logic          mute,
  output logic          codec_pd,
  output logic          cfg_err
);
  logic [2:0] code;
  logic       sync_sel;
  logic       scale;
  logic [2:0] rate_n;
  ext_mode_t  mode_n;
  logic       clk_bad;
  logic       sys_bad;

  assign code     = clk_reg[CK_RATE_HI:CK_RATE_LO];
  assign sync_sel = clk_reg[CK_SYNC];
  assign scale    = clk_reg[CK_SCALE];
  assign sys_bad  = (sys_reg[SY_MODE_HI:SY_MODE_LO] == 2'b10);

  always_comb begin
    rate_n  = '0;
    mode_n  = EXT_SPDIF;
    clk_bad = 1'b0;
    if (!sync_sel) begin
      rate_n  = code;
      clk_bad = (code > 3'(RATE_MAX));
    end else begin
      unique case ({scale, code})
        4'b0000: mode_n = EXT_SPDIF;
        4'b0010: mode_n = EXT_WC1;
        4'b1010: mode_n = EXT_WC256;
        default: begin
          mode_n  = EXT_BAD;
          clk_bad = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_idx <= '0;
      ext_mode <= EXT_SPDIF;
      ext_sync <= 1'b0;
      mute     <= 1'b0;
      codec_pd <= 1'b1;
      cfg_err  <= 1'b0;
    end else begin
      rate_idx <= rate_n;
      ext_mode <= mode_n;
      ext_sync <= sync_sel;
      mute     <= sys_reg[SY_MUTE];
      codec_pd <= ~sys_reg[SY_PWR];
      cfg_err  <= cfg_err | clk_bad | sys_bad;
    end
  end
endmodule

// File: rtl/cfg_latch_bank.sv
module cfg_latch_bank
  import cfg_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [DATA_W-1:0]   bus_d,
  input  logic                oe_n,
  input  logic                ld_sys_n,
  input  logic                ld_mon_n,
  input  logic                ld_clk_n,
  output logic [DATA_W-1:0]   sys_reg,
  output logic [DATA_W-1:0]   mon_reg,
  output logic [DATA_W-1:0]   clk_reg,
  output logic [2:0]          rate_idx,
  output logic [1:0]          ext_mode,
  output logic                ext_sync,
  output logic                mute,
  output logic                codec_pd,
  output logic                cfg_err
);
  localparam int CTRL_W = NUM_REGS + 1;

  logic [CTRL_W-1:0] ctrl_raw, ctrl_s;
  logic [DATA_W-1:0] bus_s;
  logic [NUM_REGS-1:0] strb_raw;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  ext_mode_t mode_q;

  assign strb_raw[SLOT_SYS] = ld_sys_n;
  assign strb_raw[SLOT_MON] = ld_mon_n;
  assign strb_raw[SLOT_CLK] = ld_clk_n;
  assign ctrl_raw = {oe_n, strb_raw};

  cfg_sync #(.W(CTRL_W), .STAGES(SYNC_STG), .RST_VAL('1)) u_sync_ctrl (
    .clk(clk), .rst(rst), .d(ctrl_raw), .q(ctrl_s)
  );

  cfg_sync #(.W(DATA_W), .STAGES(SYNC_STG), .RST_VAL('1)) u_sync_bus (
    .clk(clk), .rst(rst), .d(bus_d), .q(bus_s)
  );

  cfg_reg_file #(.N(NUM_REGS), .DW(DATA_W)) u_regs (
    .clk(clk), .rst(rst),
    .strb_n(ctrl_s[NUM_REGS-1:0]),
    .oe_n(ctrl_s[NUM_REGS]),
    .bus(bus_s),
    .regs(regs)
  );

  assign sys_reg = regs[SLOT_SYS];
  assign mon_reg = regs[SLOT_MON];
  assign clk_reg = regs[SLOT_CLK];

  cfg_decode #(.DW(DATA_W)) u_dec (
    .clk(clk), .rst(rst),
    .clk_reg(regs[SLOT_CLK]), .sys_reg(regs[SLOT_SYS]),
    .rate_idx(rate_idx), .ext_mode(mode_q), .ext_sync(ext_sync),
    .mute(mute), .codec_pd(codec_pd), .cfg_err(cfg_err)
  );

  assign ext_mode = mode_q;
endmodule

// File: rtl/cfg_latch_bank_chk.sv
module cfg_latch_bank_chk (
  input logic       clk,
  input logic       rst,
  input logic       oe_n,
  input logic [7:0] sys_reg,
  input logic [7:0] mon_reg,
  input logic [7:0] clk_reg,
  input logic [2:0] rate_idx,
  input logic [1:0] ext_mode,
  input logic       ext_sync,
  input logic       mute,
  input logic       codec_pd,
  input logic       cfg_err
);
  logic [3:0] oe_hi_cnt;

  always_ff @(posedge clk) begin
    if (rst || !oe_n) oe_hi_cnt <= '0;
    else if (oe_hi_cnt != 4'hF) oe_hi_cnt <= oe_hi_cnt + 4'd1;
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (sys_reg == 8'h00 && mon_reg == 8'h00 && clk_reg == 8'h00 && !cfg_err));

  a_r3_oe_blocks_load: assert property (@(posedge clk) disable iff (rst)
    (oe_hi_cnt >= 4'd5) |=> ($stable(sys_reg) && $stable(mon_reg) && $stable(clk_reg)));

  a_r7_ext_rate_zero: assert property (@(posedge clk) disable iff (rst)
    ext_sync |-> (rate_idx == 3'd0));

  a_r8_bad_mode_flags: assert property (@(posedge clk) disable iff (rst)
    (ext_mode == 2'd3) |-> cfg_err);

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);

  a_r11_mute_follow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (mute == $past(sys_reg[2]) && codec_pd == !$past(sys_reg[7])));
endmodule

bind cfg_latch_bank cfg_latch_bank_chk u_chk (.*);

// File: tb/cfg_latch_bank_test.sv
`timescale 1ns/1ps
module cfg_latch_bank_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_d = 8'hFF;
  logic       oe_n = 1'b1;
  logic [2:0] ld_n = 3'b111;
  logic [7:0] sys_reg, mon_reg, clk_reg;
  logic [2:0] rate_idx;
  logic [1:0] ext_mode;
  logic       ext_sync, mute, codec_pd, cfg_err;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cfg_latch_bank uut (
    .clk(clk), .rst(rst), .bus_d(bus_d), .oe_n(oe_n),
    .ld_sys_n(ld_n[0]), .ld_mon_n(ld_n[1]), .ld_clk_n(ld_n[2]),
    .sys_reg(sys_reg), .mon_reg(mon_reg), .clk_reg(clk_reg),
    .rate_idx(rate_idx), .ext_mode(ext_mode), .ext_sync(ext_sync),
    .mute(mute), .codec_pd(codec_pd), .cfg_err(cfg_err)
  );

  // data, ext_sync, rate_idx, ext_mode
  localparam int NV = 9;
  localparam logic [13:0] VEC [NV] = '{
    {8'h00, 1'b0, 3'd0, 2'd0},
    {8'h41, 1'b0, 3'd1, 2'd0},
    {8'h22, 1'b0, 3'd2, 2'd0},
    {8'h83, 1'b0, 3'd3, 2'd0},
    {8'hE4, 1'b0, 3'd4, 2'd0},
    {8'h05, 1'b0, 3'd5, 2'd0},
    {8'hA8, 1'b1, 3'd0, 2'd0},
    {8'h4A, 1'b1, 3'd0, 2'd1},
    {8'h3A, 1'b1, 3'd0, 2'd2}
  };

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    step(3); rst = 1'b0;
    step(3);
  endtask

  task automatic strobe_low(int sel, logic [7:0] d, bit enable);
    @(negedge clk); bus_d = d;
    step(2); oe_n = !enable;
    step(2); ld_n[sel] = 1'b0;
    step(4);
  endtask

  task automatic strobe_high();
    ld_n = 3'b111;
    step(3); oe_n = 1'b1; bus_d = 8'hFF;
    step(8);
  endtask

  task automatic wr(int sel, logic [7:0] d);
    strobe_low(sel, d, 1'b1);
    strobe_high();
  endtask

  initial begin
    step(4);
    rst = 1'b0;
    step(3);
    // R1 reset state
    chk("R1 sys_reg", sys_reg, 8'h00);
    chk("R1 mon_reg", mon_reg, 8'h00);
    chk("R1 clk_reg", clk_reg, 8'h00);
    chk("R1 rate_idx", {5'd0, rate_idx}, 8'h00);
    chk("R1 ext_mode", {6'd0, ext_mode}, 8'h00);
    chk("R1 flags", {4'd0, ext_sync, mute, codec_pd, cfg_err}, 8'h02);

    // R5 / R7 legal clock encodings
    for (int i = 0; i < NV; i++) begin
      wr(2, VEC[i][13:6]);
      chk("R5_R7 clk_reg", clk_reg, VEC[i][13:6]);
      chk("R5_R7 ext_sync", {7'd0, ext_sync}, {7'd0, VEC[i][5]});
      chk("R5_R7 rate_idx", {5'd0, rate_idx}, {5'd0, VEC[i][4:2]});
      chk("R5_R7 ext_mode", {6'd0, ext_mode}, {6'd0, VEC[i][1:0]});
      chk("R5_R7 no error", {7'd0, cfg_err}, 8'h00);
    end

    // R2 no load before rising edge, only addressed register loads
    strobe_low(0, 8'h84, 1'b1);
    chk("R2 held while strobe low", sys_reg, 8'h00);
    strobe_high();
    chk("R2 sys loaded", sys_reg, 8'h84);
    chk("R2 mon untouched", mon_reg, 8'h00);
    chk("R2 clk untouched", clk_reg, 8'h3A);
    // R11 mute / codec power
    chk("R11 mute set", {7'd0, mute}, 8'h01);
    chk("R11 codec powered", {7'd0, codec_pd}, 8'h00);
    wr(0, 8'h00);
    chk("R11 mute clear", {7'd0, mute}, 8'h00);
    chk("R11 codec down", {7'd0, codec_pd}, 8'h01);

    wr(1, 8'h3F);
    chk("R2 mon loaded", mon_reg, 8'h3F);

    // R3 strobe with enable inactive
    strobe_low(1, 8'h55, 1'b0);
    strobe_high();
    chk("R3 mon unchanged", mon_reg, 8'h3F);
    strobe_low(2, 8'h55, 1'b0);
    strobe_high();
    chk("R3 clk unchanged", clk_reg, 8'h3A);

    // R4 idle bus not captured; R9 legal input modes
    wr(0, 8'h30);
    step(20);
    chk("R4 sys keeps value", sys_reg, 8'h30);
    chk("R9 mode 11 legal", {7'd0, cfg_err}, 8'h00);
    wr(0, 8'h10);
    chk("R9 mode 01 legal", {7'd0, cfg_err}, 8'h00);

    // R9 forbidden input mode
    wr(0, 8'h20);
    chk("R9 mode 10 error", {7'd0, cfg_err}, 8'h01);
    // R10 sticky after legal writes
    wr(0, 8'h00);
    wr(2, 8'h01);
    chk("R10 error sticky", {7'd0, cfg_err}, 8'h01);
    do_reset();
    chk("R10 reset clears", {7'd0, cfg_err}, 8'h00);
    chk("R1 clk_reg after reset", clk_reg, 8'h00);

    // R6 invalid internal rates
    wr(2, 8'h06);
    chk("R6 code 6 error", {7'd0, cfg_err}, 8'h01);
    do_reset();
    wr(2, 8'hC7);
    chk("R6 code 7 error", {7'd0, cfg_err}, 8'h01);
    do_reset();

    // R8 illegal external patterns
    wr(2, 8'h0C);
    chk("R8 ext rate 100 error", {7'd0, cfg_err}, 8'h01);
    chk("R8 ext_mode invalid", {6'd0, ext_mode}, 8'h03);
    do_reset();
    wr(2, 8'h18);
    chk("R8 ext scale 1 rate 000 error", {7'd0, cfg_err}, 8'h01);
    chk("R8 ext_sync", {7'd0, ext_sync}, 8'h01);
    do_reset();

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      fails++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule